// File: doc/BRIEF.md
# SHA-1 Block Compression Engine

This block performs one SHA-1 compression step on a single 512-bit message block. The host first loads sixteen 32-bit big-endian message words through a word-write port. It then presents a 160-bit chaining value and pulses `start`. The engine returns the updated chaining value after a fixed number of cycles and signals this with a one-cycle `done`. Padding, the sequencing of several blocks and any keyed-hash control belong to the surrounding logic. That logic chains blocks by feeding `cv_out` back into `cv_in`.

A single round datapath is reused for all 80 rounds. The message schedule lives in an 80-word store. Words 0 to 15 hold the loaded block. Each later schedule word is computed from four earlier words and written back at its own index. Those four reads are issued one cycle ahead of the round that consumes the word.

Top module: `sha1_round_engine`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy` and `done` are 0 and `cv_out` is all zeros until the first run completes.
- R2: A `start` sampled high while `busy` is low makes `busy` high from the next cycle for exactly 82 consecutive cycles (one prefetch cycle, 80 round cycles, one fold cycle).
- R3: `done` is high for exactly one cycle, the first cycle in which `busy` is low again after a run.
- R4: When `done` is high, `cv_out` equals the SHA-1 compression of the loaded block with the sampled chaining value. Word A is bits 159:128 and word E is bits 31:0, and message word t is written at `wr_addr` = t. Rounds 0-19 use (B&C)|(~B&D) with 0x5A827999. Rounds 20-39 use B^C^D with 0x6ED9EBA1. Rounds 40-59 use (B&C)|(B&D)|(C&D) with 0x8F1BBCDC. Rounds 60-79 use B^C^D with 0xCA62C1D6. W[t] for t≥16 is rotl1(W[t-3]^W[t-8]^W[t-14]^W[t-16]). The chaining words are added modulo 2^32 after round 79.
- R5: `cv_out` changes only in the cycle `done` is high, and otherwise holds its value.
- R6: `start` sampled while `busy` is high has no effect on the run in progress or on its timing.
- R7: Word writes sampled while `busy` is high are discarded, and the stored message is unchanged.
- R8: Stored message words 0-15 survive a run, so a second `start` without reloading compresses the same block.
- R9: `cv_in` is sampled only on the cycle a `start` is accepted, and later changes during the run do not affect the result.
- R10: A `start` presented in the cycle `done` is high is accepted, which gives back-to-back runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Begin a compression when idle |
| wr_en | input | 1 | Message word write strobe |
| wr_addr | input | 4 | Message word index 0-15 |
| wr_data | input | 32 | Message word value |
| cv_in | input | 160 | Input chaining value, A in the top word |
| busy | output | 1 | Compression in progress |
| done | output | 1 | One-cycle completion pulse |
| cv_out | output | 160 | Updated chaining value |

## Verification
A reference model in the bench tracks `busy`, `done` and `cv_out` on every clock. It computes the digest with its own behavioural SHA-1, and the well-known three-byte test vector anchors it independently. The bench targets four failure modes:
- An off-by-one in the prefetch pipeline would feed the wrong schedule word to a round and corrupt every digest.
- A schedule write-back that strays into words 0-15 would break a rerun without reload.
- A write or `start` leaking through while busy would change the digest or stretch `busy`.
- Sampling `cv_in` late would make the result follow a value changed mid-run.

Back-to-back starts on the `done` cycle exercise the return to idle.

// File: rtl/sha1_core_pkg.sv
package sha1_core_pkg;

  localparam int WORD_W       = 32;
  localparam int BLOCK_WORDS  = 16;
  localparam int NUM_ROUNDS   = 80;
  localparam int STAGE_ROUNDS = 20;
  localparam int CHAIN_WORDS  = 5;
  localparam int CHAIN_W      = WORD_W * CHAIN_WORDS;
  localparam int IDX_W        = $clog2(NUM_ROUNDS);
  localparam int MSG_AW       = $clog2(BLOCK_WORDS);
  localparam int NUM_TAPS     = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
  } chain_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FILL,
    PH_RUN,
    PH_FOLD
  } phase_e;

  localparam idx_t LAST_ROUND = idx_t'(NUM_ROUNDS - 1);
  localparam idx_t STAGE1_END = idx_t'(STAGE_ROUNDS);
  localparam idx_t STAGE2_END = idx_t'(2 * STAGE_ROUNDS);
  localparam idx_t STAGE3_END = idx_t'(3 * STAGE_ROUNDS);
  localparam idx_t GEN_FIRST  = idx_t'(BLOCK_WORDS);

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t mix_fn(input idx_t t, input word_t b,
                                   input word_t c, input word_t d);
    if (t < STAGE1_END)      return (b & c) | (~b & d);
    else if (t < STAGE2_END) return b ^ c ^ d;
    else if (t < STAGE3_END) return (b & c) | (b & d) | (c & d);
    else                     return b ^ c ^ d;
  endfunction

  function automatic word_t round_const(input idx_t t);
    if (t < STAGE1_END)      return 32'h5A82_7999;
    else if (t < STAGE2_END) return 32'h6ED9_EBA1;
    else if (t < STAGE3_END) return 32'h8F1B_BCDC;
    else                     return 32'hCA62_C1D6;
  endfunction

endpackage

// File: rtl/sha1_sched_store.sv
module sha1_sched_store #(
  parameter int DEPTH = 80,
  parameter int WIDTH = 32,
  parameter int PORTS = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [AW-1:0]               waddr,
  input  logic [WIDTH-1:0]            wdata,
  input  logic [PORTS-1:0][AW-1:0]    raddr,
  output logic [PORTS-1:0][WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    always_ff @(posedge clk) begin
      rdata[p] <= mem[raddr[p]];
    end
  end

endmodule

// File: rtl/sha1_sched_expand.sv
module sha1_sched_expand
  import sha1_core_pkg::*;
(
  input  idx_t                         nxt_idx,
  input  idx_t                         cur_idx,
  input  logic [NUM_TAPS-1:0][WORD_W-1:0] rdata,
  output logic [NUM_TAPS-1:0][IDX_W-1:0]  raddr,
  output word_t                        w_cur,
  output logic                         gen
);

  localparam int TAP_OFS [NUM_TAPS] = '{3, 8, 14, 16};

  logic nxt_is_msg;
  word_t tap_xor;

  assign nxt_is_msg = (nxt_idx < GEN_FIRST);

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign raddr[k] = nxt_is_msg ? nxt_idx : (nxt_idx - idx_t'(TAP_OFS[k]));
  end

  always_comb begin
    tap_xor = '0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      tap_xor = tap_xor ^ rdata[k];
    end
  end

  assign gen   = (cur_idx >= GEN_FIRST);
  assign w_cur = gen ? rotl(tap_xor, 1) : rdata[0];

endmodule

// File: rtl/sha1_round_unit.sv
module sha1_round_unit
  import sha1_core_pkg::*;
(
  input  chain_t st,
  input  word_t  w,
  input  idx_t   t,
  output chain_t nxt
);

  word_t f_val;
  word_t k_val;

  always_comb begin
    f_val = mix_fn(t, st.b, st.c, st.d);
    k_val = round_const(t);
    nxt.a = rotl(st.a, 5) + f_val + st.e + w + k_val;
    nxt.b = st.a;
    nxt.c = rotl(st.b, 30);
    nxt.d = st.c;
    nxt.e = st.d;
  end

endmodule

// File: rtl/sha1_ctrl.sv
module sha1_ctrl
  import sha1_core_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic load,
  output logic run,
  output logic fold,
  output logic done,
  output idx_t rnd,
  output idx_t nxt_idx
);

  phase_e phase_q, phase_d;
  idx_t   rnd_q, rnd_d;
  logic   rnd_en;
  logic   done_q;

  always_comb begin
    phase_d = phase_q;
    rnd_d   = rnd_q;
    rnd_en  = 1'b0;
    load    = 1'b0;
    nxt_idx = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          load    = 1'b1;
          phase_d = PH_FILL;
        end
      end
      PH_FILL: begin
        phase_d = PH_RUN;
        rnd_d   = '0;
        rnd_en  = 1'b1;
        nxt_idx = '0;
      end
      PH_RUN: begin
        if (rnd_q == LAST_ROUND) begin
          phase_d = PH_FOLD;
          nxt_idx = '0;
        end else begin
          rnd_d   = rnd_q + idx_t'(1);
          rnd_en  = 1'b1;
          nxt_idx = rnd_q + idx_t'(1);
        end
      end
      PH_FOLD: begin
        phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= (phase_q == PH_FOLD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rnd_q <= '0;
    end else if (rnd_en) begin
      rnd_q <= rnd_d;
    end
  end

  assign busy = (phase_q != PH_IDLE);
  assign run  = (phase_q == PH_RUN);
  assign fold = (phase_q == PH_FOLD);
  assign done = done_q;
  assign rnd  = rnd_q;

endmodule

// File: rtl/sha1_round_engine.sv
module sha1_round_engine
  import sha1_core_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               wr_en,
  input  logic [MSG_AW-1:0]  wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [CHAIN_W-1:0] cv_in,
  output logic               busy,
  output logic               done,
  output logic [CHAIN_W-1:0] cv_out
);

  logic   load, run, fold;
  idx_t   rnd, nxt_idx;
  logic   gen;
  word_t  w_cur;
  chain_t round_nxt;

  chain_t work_q, work_d;
  logic   work_en;
  chain_t hold_q;
  chain_t out_q, out_d;

  logic                             st_we;
  idx_t                             st_waddr;
  word_t                            st_wdata;
  logic [NUM_TAPS-1:0][IDX_W-1:0]   st_raddr;
  logic [NUM_TAPS-1:0][WORD_W-1:0]  st_rdata;

  sha1_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .load    (load),
    .run     (run),
    .fold    (fold),
    .done    (done),
    .rnd     (rnd),
    .nxt_idx (nxt_idx)
  );

  sha1_sched_expand u_expand (
    .nxt_idx (nxt_idx),
    .cur_idx (rnd),
    .rdata   (st_rdata),
    .raddr   (st_raddr),
    .w_cur   (w_cur),
    .gen     (gen)
  );

  sha1_sched_store #(
    .DEPTH (NUM_ROUNDS),
    .WIDTH (WORD_W),
    .PORTS (NUM_TAPS)
  ) u_store (
    .clk   (clk),
    .we    (st_we),
    .waddr (st_waddr),
    .wdata (st_wdata),
    .raddr (st_raddr),
    .rdata (st_rdata)
  );

  sha1_round_unit u_round (
    .st  (work_q),
    .w   (w_cur),
    .t   (rnd),
    .nxt (round_nxt)
  );

  // Store write port: host words while idle, expanded words while running.
  always_comb begin
    if (run) begin
      st_we    = gen;
      st_waddr = rnd;
      st_wdata = w_cur;
    end else begin
      st_we    = wr_en && !busy;
      st_waddr = idx_t'(wr_addr);
      st_wdata = wr_data;
    end
  end

  always_comb begin
    work_en = load || run;
    work_d  = load ? chain_t'(cv_in) : round_nxt;
  end

  always_comb begin
    out_d.a = hold_q.a + work_q.a;
    out_d.b = hold_q.b + work_q.b;
    out_d.c = hold_q.c + work_q.c;
    out_d.d = hold_q.d + work_q.d;
    out_d.e = hold_q.e + work_q.e;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
    end else if (work_en) begin
      work_q <= work_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (load) begin
      hold_q <= chain_t'(cv_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (fold) begin
      out_q <= out_d;
    end
  end

  assign cv_out = out_q;

endmodule

// File: rtl/sha1_round_engine_chk.sv
module sha1_round_engine_chk
  import sha1_core_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [CHAIN_W-1:0] cv_out
);

  localparam int RUN_CYCLES = NUM_ROUNDS + 2;
  localparam int CNT_W      = $clog2(RUN_CYCLES + 1);

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt + CNT_W'(1);
    end else begin
      busy_cnt <= '0;
    end
  end

  p_busy_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == CNT_W'(RUN_CYCLES)));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(cv_out));

  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && (busy_cnt < CNT_W'(RUN_CYCLES - 1))) |=> busy);

endmodule

bind sha1_round_engine sha1_round_engine_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .cv_out (cv_out)
);

// File: tb/sha1_round_engine_bench.sv
module sha1_round_engine_bench;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         wr_en;
  logic [3:0]   wr_addr;
  logic [31:0]  wr_data;
  logic [159:0] cv_in;
  logic         busy;
  logic         done;
  logic [159:0] cv_out;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;

  localparam logic [159:0] IV = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

  sha1_round_engine u_sha1_round_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cv_in(cv_in),
    .busy(busy), .done(done), .cv_out(cv_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural reference
  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] ref_compress(input logic [159:0] cv,
                                                input logic [31:0] m [16]);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, tmp;
    for (int t = 0; t < 80; t++) begin
      if (t < 16) w[t] = m[t];
      else w[t] = rl(w[t-3] ^ w[t-8] ^ w[t-14] ^ w[t-16], 1);
    end
    a = cv[159:128]; b = cv[127:96]; c = cv[95:64]; d = cv[63:32]; e = cv[31:0];
    for (int t = 0; t < 80; t++) begin
      if (t < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (t < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (t < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      tmp = rl(a, 5) + f + e + w[t] + k;
      e = d; d = c; c = rl(b, 30); b = a; a = tmp;
    end
    return {cv[159:128] + a, cv[127:96] + b, cv[95:64] + c, cv[63:32] + d, cv[31:0] + e};
  endfunction

  // Cycle model
  logic [31:0]  mdl_msg [16];
  logic [159:0] mdl_cv_hold = '0;
  logic [159:0] exp_cv      = '0;
  logic         exp_busy    = 1'b0;
  logic         exp_done    = 1'b0;
  int           mdl_cnt     = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_busy = 1'b0; exp_done = 1'b0; exp_cv = '0; mdl_cnt = 0;
    end else begin
      exp_done = 1'b0;
      if (!exp_busy) begin
        if (wr_en) mdl_msg[wr_addr] = wr_data;
        if (start) begin
          exp_busy = 1'b1; mdl_cnt = 0; mdl_cv_hold = cv_in;
        end
      end else begin
        mdl_cnt++;
        if (mdl_cnt == 82) begin
          exp_busy = 1'b0; exp_done = 1'b1;
          exp_cv = ref_compress(mdl_cv_hold, mdl_msg);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 busy", {159'b0, busy}, {159'b0, exp_busy});
      chk("R3 done", {159'b0, done}, {159'b0, exp_done});
      chk("R4/R5 cv_out", cv_out, exp_cv);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic write_word(input int idx, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(idx); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_block(input logic [31:0] m [16]);
    for (int i = 0; i < 16; i++) write_word(i, m[i]);
  endtask

  task automatic pulse_start(input logic [159:0] cv);
    @(negedge clk);
    start = 1'b1; cv_in = cv;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  logic [31:0]  blk [16];
  logic [159:0] saved;

  initial begin
    rst_n = 1'b0; start = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; cv_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy/done", {158'b0, busy, done}, '0);
    chk("R1 reset cv_out", cv_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", cv_out, '0);

    // Three-byte test vector
    for (int i = 0; i < 16; i++) blk[i] = '0;
    blk[0] = 32'h61626380; blk[15] = 32'h00000018;
    load_block(blk);
    pulse_start(IV);
    wait_done();
    chk("R4 known vector", cv_out,
        160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);
    saved = cv_out;
    repeat (10) @(negedge clk);
    chk("R5 hold after done", cv_out, saved);

    // Rerun without reload, disturbing start, writes and cv_in while busy
    pulse_start(IV);
    repeat (5) @(negedge clk);
    cv_in = ~IV;
    start = 1'b1;
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'hDEADBEEF;
    repeat (20) @(negedge clk);
    start = 1'b0; wr_en = 1'b0;
    wait_done();
    chk("R6 R7 R8 R9 rerun digest", cv_out, saved);

    // Chained block with a patterned message
    for (int i = 0; i < 16; i++) blk[i] = 32'h01234567 * (i + 3) ^ {16'(i), 16'hA5C3};
    load_block(blk);
    pulse_start(saved);
    wait_done();
    chk("R4 chained block", cv_out, ref_compress(saved, blk));

    // All-ones block, then back-to-back start on the done cycle
    for (int i = 0; i < 16; i++) blk[i] = 32'hFFFFFFFF;
    load_block(blk);
    pulse_start(160'h0);
    wait_done();
    chk("R4 all-ones block", cv_out, ref_compress(160'h0, blk));
    start = 1'b1; cv_in = IV;
    @(negedge clk);
    start = 1'b0;
    chk("R10 back-to-back accepted", {159'b0, busy}, {159'b0, 1'b1});
    wait_done();
    chk("R10 back-to-back digest", cv_out, ref_compress(IV, blk));

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule